// File: doc/BRIEF.md
# Grouped Conjugate-Weight Array Combiner

This block turns one snapshot of complex baseband samples from a 32-element antenna array into a single beam sample. Each element's sample is multiplied by the complex conjugate of a stored per-element weight. The products are added in eight partial combiners of four elements each, and a final adder sums the eight partial results. The full-precision sum is rounded and saturated back to the 16-bit sample format. The block also takes a reference sample that arrives with the array snapshot. Next to the beam it returns the error between that reference and the beam, which a weight-adaptation engine outside the block can use.

Weights are loaded one element at a time through a single-cycle write port. A weight is a signed Q1.15 complex value; samples are signed 16-bit I/Q. The datapath is a fixed four-stage pipeline that accepts a new snapshot on every clock. An output valid marks the cycle in which the beam and the error for a snapshot appear together.

Top module: `bf_array_combiner`

## Requirements
- R1: Element k contributes wi·xi + wq·xq to the real part and wi·xq − wq·xi to the imaginary part of the full-precision sum. Here (wi, wq) is its stored weight and (xi, xq) is its sample, so each sample is multiplied by the conjugate of its weight.
- R2: The beam is the sum of the contributions of all 32 elements. Element k's sample sits at bits [16k+15:16k] of in_samp_i and in_samp_q. Elements 4g to 4g+3 form partial combiner g, and the eight partial sums are added in a separate stage.
- R3: The full-precision sum is scaled by 2^-15 with round-half-up: 2^14 is added, then the value is shifted right arithmetically by 15.
- R4: Each rounded component saturates to the range −32768 to 32767.
- R5: Per component, out_err equals the reference minus the saturated beam output, itself saturated to −32768 to 32767. It is presented in the same cycle as the beam.
- R6: A snapshot accepted on rising edge n (in_valid high) yields out_valid high for one cycle after rising edge n+3. out_valid is low in every other cycle, and back-to-back snapshots are accepted on consecutive edges.
- R7: A weight written on rising edge n applies to snapshots accepted on edge n+1 and later. A snapshot accepted on the same edge as the write uses the earlier weight, so every output is formed from one complete weight set.
- R8: Synchronous active-high reset clears out_valid, all four outputs and all 32 weights. The first snapshot after reset therefore gives a zero beam and an error equal to the reference.
- R9: A write with wr_en high replaces only the weight of element wr_addr, with wr_wi as its real part and wr_wq as its imaginary part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Snapshot on the sample and reference inputs is valid |
| in_samp_i | input | 512 | Real parts of the 32 element samples, element k at [16k+15:16k] |
| in_samp_q | input | 512 | Imaginary parts of the 32 element samples |
| in_ref_i | input | 16 | Real part of the reference sample |
| in_ref_q | input | 16 | Imaginary part of the reference sample |
| wr_en | input | 1 | Weight write strobe |
| wr_addr | input | 5 | Element whose weight is written |
| wr_wi | input | 16 | Real part of the written weight (Q1.15) |
| wr_wq | input | 16 | Imaginary part of the written weight (Q1.15) |
| out_valid | output | 1 | Beam and error outputs are valid |
| out_beam_i | output | 16 | Real part of the beam sample |
| out_beam_q | output | 16 | Imaginary part of the beam sample |
| out_err_i | output | 16 | Real part of reference minus beam |
| out_err_q | output | 16 | Imaginary part of reference minus beam |

## Verification
Some properties are checked on every clock: the fixed spacing between in_valid and out_valid, the quiet outputs after reset, the error being the delayed reference minus the presented beam with saturation, and a silent array producing a zero beam. The arithmetic is checked only by the bench's scenarios against a bench model. This covers conjugation, summation over all elements and groups, the rounding tie, saturation at both rails, and when a weight write takes effect relative to a snapshot on the same edge.

// File: rtl/bf_comb_pkg.sv
package bf_comb_pkg;

  localparam int unsigned DEF_GROUPS     = 8;
  localparam int unsigned DEF_GROUP_SIZE = 4;
  localparam int unsigned DEF_DW         = 16;

  // Clamp a wide signed value into the range of a w-bit signed number.
  function automatic logic signed [63:0] clamp_to(input logic signed [63:0] v,
                                                  input int unsigned w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // Scale by 2^-f, rounding ties toward positive infinity.
  function automatic logic signed [63:0] round_shift(input logic signed [63:0] v,
                                                     input int unsigned f);
    if (f == 0) return v;
    return (v + (64'sd1 <<< (f - 1))) >>> f;
  endfunction

endpackage

// File: rtl/bf_weight_bank.sv
module bf_weight_bank #(
  parameter int unsigned NCH = 32,
  parameter int unsigned DW  = 16,
  parameter int unsigned AW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_wi,
  input  logic [DW-1:0]     wr_wq,
  output logic [NCH*DW-1:0] w_i_flat,
  output logic [NCH*DW-1:0] w_q_flat
);

  logic [DW-1:0] wi_r [NCH];
  logic [DW-1:0] wq_r [NCH];

  // Single addressed write per cycle; all entries read in parallel.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        wi_r[c] <= '0;
        wq_r[c] <= '0;
      end
    end else if (wr_en) begin
      wi_r[wr_addr] <= wr_wi;
      wq_r[wr_addr] <= wr_wq;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_flat
    assign w_i_flat[c*DW +: DW] = wi_r[c];
    assign w_q_flat[c*DW +: DW] = wq_r[c];
  end

endmodule

// File: rtl/bf_partial_combiner.sv
module bf_partial_combiner #(
  parameter int unsigned GS = 4,
  parameter int unsigned DW = 16,
  parameter int unsigned PW = 2 * DW + 1,
  parameter int unsigned GW = PW + ((GS > 1) ? $clog2(GS) : 0)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [GS*DW-1:0]     x_i,
  input  logic [GS*DW-1:0]     x_q,
  input  logic [GS*DW-1:0]     w_i,
  input  logic [GS*DW-1:0]     w_q,
  output logic signed [GW-1:0] grp_re,
  output logic signed [GW-1:0] grp_im
);

  localparam int unsigned MW = 2 * DW;

  logic signed [PW-1:0] p_re_d [GS];
  logic signed [PW-1:0] p_im_d [GS];
  logic signed [PW-1:0] p_re_q [GS];
  logic signed [PW-1:0] p_im_q [GS];
  logic signed [GW-1:0] sum_re;
  logic signed [GW-1:0] sum_im;

  // Stage 1: conjugate multiply, (a - jb)(c + jd) = (ac + bd) + j(ad - bc)
  for (genvar k = 0; k < GS; k++) begin : g_lane
    logic signed [DW-1:0] a, b, c, d;
    logic signed [MW-1:0] ac, bd, ad, bc;
    assign a  = w_i[k*DW +: DW];
    assign b  = w_q[k*DW +: DW];
    assign c  = x_i[k*DW +: DW];
    assign d  = x_q[k*DW +: DW];
    assign ac = MW'(a) * MW'(c);
    assign bd = MW'(b) * MW'(d);
    assign ad = MW'(a) * MW'(d);
    assign bc = MW'(b) * MW'(c);
    assign p_re_d[k] = PW'(ac) + PW'(bd);
    assign p_im_d[k] = PW'(ad) - PW'(bc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < GS; k++) begin
        p_re_q[k] <= '0;
        p_im_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < GS; k++) begin
        p_re_q[k] <= p_re_d[k];
        p_im_q[k] <= p_im_d[k];
      end
    end
  end

  // Stage 2: group sum at full precision
  always_comb begin
    sum_re = '0;
    sum_im = '0;
    for (int k = 0; k < GS; k++) begin
      sum_re = sum_re + GW'(p_re_q[k]);
      sum_im = sum_im + GW'(p_im_q[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_re <= '0;
      grp_im <= '0;
    end else begin
      grp_re <= sum_re;
      grp_im <= sum_im;
    end
  end

endmodule

// File: rtl/bf_beam_adder.sv
module bf_beam_adder
  import bf_comb_pkg::*;
#(
  parameter int unsigned NG   = 8,
  parameter int unsigned GW   = 35,
  parameter int unsigned BW   = GW + ((NG > 1) ? $clog2(NG) : 0),
  parameter int unsigned DW   = 16,
  parameter int unsigned FRAC = DW - 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NG*GW-1:0]     grp_re_flat,
  input  logic [NG*GW-1:0]     grp_im_flat,
  input  logic signed [DW-1:0] ref_i,
  input  logic signed [DW-1:0] ref_q,
  output logic [DW-1:0]        beam_i,
  output logic [DW-1:0]        beam_q,
  output logic [DW-1:0]        err_i,
  output logic [DW-1:0]        err_q
);

  logic signed [GW-1:0] g_re [NG];
  logic signed [GW-1:0] g_im [NG];
  logic signed [BW-1:0] acc_re, acc_im;
  logic signed [BW-1:0] beam_re_q, beam_im_q;
  logic signed [DW-1:0] ref_i_q, ref_q_q;
  logic signed [DW-1:0] b_re_n, b_im_n, e_re_n, e_im_n;

  for (genvar g = 0; g < NG; g++) begin : g_unpack
    assign g_re[g] = grp_re_flat[g*GW +: GW];
    assign g_im[g] = grp_im_flat[g*GW +: GW];
  end

  // Stage 3: sum of the partial combiners, reference aligned alongside
  always_comb begin
    acc_re = '0;
    acc_im = '0;
    for (int g = 0; g < NG; g++) begin
      acc_re = acc_re + BW'(g_re[g]);
      acc_im = acc_im + BW'(g_im[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beam_re_q <= '0;
      beam_im_q <= '0;
      ref_i_q   <= '0;
      ref_q_q   <= '0;
    end else begin
      beam_re_q <= acc_re;
      beam_im_q <= acc_im;
      ref_i_q   <= ref_i;
      ref_q_q   <= ref_q;
    end
  end

  // Stage 4: round, saturate, then form the error from the narrowed beam
  assign b_re_n = DW'(clamp_to(round_shift(64'(beam_re_q), FRAC), DW));
  assign b_im_n = DW'(clamp_to(round_shift(64'(beam_im_q), FRAC), DW));
  assign e_re_n = DW'(clamp_to(64'(ref_i_q) - 64'(b_re_n), DW));
  assign e_im_n = DW'(clamp_to(64'(ref_q_q) - 64'(b_im_n), DW));

  always_ff @(posedge clk) begin
    if (rst) begin
      beam_i <= '0;
      beam_q <= '0;
      err_i  <= '0;
      err_q  <= '0;
    end else begin
      beam_i <= b_re_n;
      beam_q <= b_im_n;
      err_i  <= e_re_n;
      err_q  <= e_im_n;
    end
  end

endmodule

// File: rtl/bf_array_combiner.sv
module bf_array_combiner
  import bf_comb_pkg::*;
#(
  parameter int unsigned NG   = DEF_GROUPS,
  parameter int unsigned GS   = DEF_GROUP_SIZE,
  parameter int unsigned DW   = DEF_DW,
  parameter int unsigned FRAC = DW - 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [NG*GS*DW-1:0]          in_samp_i,
  input  logic [NG*GS*DW-1:0]          in_samp_q,
  input  logic [DW-1:0]                in_ref_i,
  input  logic [DW-1:0]                in_ref_q,
  input  logic                         wr_en,
  input  logic [$clog2(NG*GS)-1:0]     wr_addr,
  input  logic [DW-1:0]                wr_wi,
  input  logic [DW-1:0]                wr_wq,
  output logic                         out_valid,
  output logic [DW-1:0]                out_beam_i,
  output logic [DW-1:0]                out_beam_q,
  output logic [DW-1:0]                out_err_i,
  output logic [DW-1:0]                out_err_q
);

  localparam int unsigned NCH = NG * GS;
  localparam int unsigned AW  = $clog2(NCH);
  localparam int unsigned PW  = 2 * DW + 1;
  localparam int unsigned GW  = PW + ((GS > 1) ? $clog2(GS) : 0);
  localparam int unsigned BW  = GW + ((NG > 1) ? $clog2(NG) : 0);
  localparam int unsigned LAT = 4;   // multiply, group sum, beam sum, narrow
  localparam int unsigned RLAT = 2;  // reference delay ahead of the beam adder

  logic [NCH*DW-1:0] w_i_flat, w_q_flat;
  logic [NG*GW-1:0]  grp_re_flat, grp_im_flat;
  logic [LAT-1:0]    vpipe;
  logic signed [DW-1:0] ref_i_p [RLAT];
  logic signed [DW-1:0] ref_q_p [RLAT];

  bf_weight_bank #(.NCH(NCH), .DW(DW), .AW(AW)) u_wbank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_wi    (wr_wi),
    .wr_wq    (wr_wq),
    .w_i_flat (w_i_flat),
    .w_q_flat (w_q_flat)
  );

  for (genvar g = 0; g < NG; g++) begin : g_group
    logic signed [GW-1:0] re_g, im_g;
    bf_partial_combiner #(.GS(GS), .DW(DW), .PW(PW), .GW(GW)) u_pc (
      .clk    (clk),
      .rst    (rst),
      .x_i    (in_samp_i[g*GS*DW +: GS*DW]),
      .x_q    (in_samp_q[g*GS*DW +: GS*DW]),
      .w_i    (w_i_flat[g*GS*DW +: GS*DW]),
      .w_q    (w_q_flat[g*GS*DW +: GS*DW]),
      .grp_re (re_g),
      .grp_im (im_g)
    );
    assign grp_re_flat[g*GW +: GW] = re_g;
    assign grp_im_flat[g*GW +: GW] = im_g;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < RLAT; s++) begin
        ref_i_p[s] <= '0;
        ref_q_p[s] <= '0;
      end
    end else begin
      ref_i_p[0] <= in_ref_i;
      ref_q_p[0] <= in_ref_q;
      for (int s = 1; s < RLAT; s++) begin
        ref_i_p[s] <= ref_i_p[s-1];
        ref_q_p[s] <= ref_q_p[s-1];
      end
    end
  end

  bf_beam_adder #(.NG(NG), .GW(GW), .BW(BW), .DW(DW), .FRAC(FRAC)) u_adder (
    .clk         (clk),
    .rst         (rst),
    .grp_re_flat (grp_re_flat),
    .grp_im_flat (grp_im_flat),
    .ref_i       (ref_i_p[RLAT-1]),
    .ref_q       (ref_q_p[RLAT-1]),
    .beam_i      (out_beam_i),
    .beam_q      (out_beam_q),
    .err_i       (out_err_i),
    .err_q       (out_err_q)
  );

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[LAT-2:0], in_valid};
  end

  assign out_valid = vpipe[LAT-1];

endmodule

// File: rtl/bf_array_combiner_chk.sv
module bf_array_combiner_chk
  import bf_comb_pkg::*;
#(
  parameter int unsigned NG = 8,
  parameter int unsigned GS = 4,
  parameter int unsigned DW = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [NG*GS*DW-1:0] in_samp_i,
  input logic [NG*GS*DW-1:0] in_samp_q,
  input logic [DW-1:0]       in_ref_i,
  input logic [DW-1:0]       in_ref_q,
  input logic                out_valid,
  input logic [DW-1:0]       out_beam_i,
  input logic [DW-1:0]       out_beam_q,
  input logic [DW-1:0]       out_err_i,
  input logic [DW-1:0]       out_err_q
);

  localparam int unsigned D = 4;

  logic [D-1:0]  vd, zd;
  logic [DW-1:0] rdi [D];
  logic [DW-1:0] rdq [D];
  logic [DW-1:0] exp_ei, exp_eq;

  always_ff @(posedge clk) begin
    if (rst) begin
      vd <= '0;
      zd <= '0;
      for (int s = 0; s < D; s++) begin
        rdi[s] <= '0;
        rdq[s] <= '0;
      end
    end else begin
      vd <= {vd[D-2:0], in_valid};
      zd <= {zd[D-2:0], in_valid && (in_samp_i == '0) && (in_samp_q == '0)};
      rdi[0] <= in_ref_i;
      rdq[0] <= in_ref_q;
      for (int s = 1; s < D; s++) begin
        rdi[s] <= rdi[s-1];
        rdq[s] <= rdq[s-1];
      end
    end
  end

  assign exp_ei = DW'(clamp_to(64'($signed(rdi[D-1])) - 64'($signed(out_beam_i)), DW));
  assign exp_eq = DW'(clamp_to(64'($signed(rdq[D-1])) - 64'($signed(out_beam_q)), DW));

  // R6: output valid trails input valid by exactly four edges
  a_r6_valid_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == vd[D-1]);

  // R8: reset leaves the output quiet
  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> (!out_valid && out_beam_i == '0 && out_err_i == '0));

  // R5: error is the aligned reference minus the presented beam
  a_r5_err_real: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_err_i == exp_ei);

  a_r5_err_imag: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_err_q == exp_eq);

  // R2: a silent array gives a zero beam whatever the weights
  a_r2_zero_samples_zero_beam: assert property (@(posedge clk) disable iff (rst)
    (out_valid && zd[D-1]) |-> (out_beam_i == '0 && out_beam_q == '0));

endmodule

bind bf_array_combiner bf_array_combiner_chk #(.NG(NG), .GS(GS), .DW(DW)) u_chk (.*);

// File: tb/bf_array_combiner_test.sv
module bf_array_combiner_test;

  localparam int NCH = 32;
  localparam int DW  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [NCH*DW-1:0] in_samp_i = '0;
  logic [NCH*DW-1:0] in_samp_q = '0;
  logic [DW-1:0]     in_ref_i = '0;
  logic [DW-1:0]     in_ref_q = '0;
  logic              wr_en = 1'b0;
  logic [4:0]        wr_addr = '0;
  logic [DW-1:0]     wr_wi = '0;
  logic [DW-1:0]     wr_wq = '0;
  logic              out_valid;
  logic [DW-1:0]     out_beam_i, out_beam_q, out_err_i, out_err_q;

  always #10 clk = ~clk;

  bf_array_combiner uut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_samp_i(in_samp_i), .in_samp_q(in_samp_q),
    .in_ref_i(in_ref_i), .in_ref_q(in_ref_q),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_wi(wr_wi), .wr_wq(wr_wq),
    .out_valid(out_valid), .out_beam_i(out_beam_i), .out_beam_q(out_beam_q),
    .out_err_i(out_err_i), .out_err_q(out_err_q)
  );

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;

  int si [NCH];
  int sq [NCH];
  int wmi [NCH];
  int wmq [NCH];
  int ri = 0, rq = 0;

  typedef struct {
    int bi; int bq; int ei; int eq;
    longint due;
    string tag;
  } exp_t;
  exp_t pend [$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint sat16(input longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint rnd15(input longint v);
    return sat16((v + 16384) >>> 15);
  endfunction

  function automatic int rs16(input int shift);
    return int'($signed(16'($urandom()))) >>> shift;
  endfunction

  // One clock: optional snapshot (using weights before any write this cycle)
  // and optional weight write.
  task automatic step(input bit do_s, input string tag, input bit do_w,
                      input int waddr, input int wi, input int wq);
    exp_t e;
    longint ar, ai;
    ar = 0;
    ai = 0;
    in_valid = do_s;
    wr_en    = do_w;
    if (do_s) begin
      for (int k = 0; k < NCH; k++) begin
        in_samp_i[k*DW +: DW] = 16'(si[k]);
        in_samp_q[k*DW +: DW] = 16'(sq[k]);
        ar += longint'(wmi[k]) * longint'(si[k]) + longint'(wmq[k]) * longint'(sq[k]);
        ai += longint'(wmi[k]) * longint'(sq[k]) - longint'(wmq[k]) * longint'(si[k]);
      end
      in_ref_i = 16'(ri);
      in_ref_q = 16'(rq);
      e.bi  = int'(rnd15(ar));
      e.bq  = int'(rnd15(ai));
      e.ei  = int'(sat16(longint'(ri) - longint'(e.bi)));
      e.eq  = int'(sat16(longint'(rq) - longint'(e.bq)));
      e.due = cyc + 4;
      e.tag = tag;
      pend.push_back(e);
    end
    if (do_w) begin
      wr_addr = 5'(waddr);
      wr_wi   = 16'(wi);
      wr_wq   = 16'(wq);
      wmi[waddr] = wi;
      wmq[waddr] = wq;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    wr_en    = 1'b0;
  endtask

  task automatic clear_samples();
    for (int k = 0; k < NCH; k++) begin
      si[k] = 0;
      sq[k] = 0;
    end
  endtask

  task automatic clear_weights();
    for (int k = 0; k < NCH; k++) step(1'b0, "", 1'b1, k, 0, 0);
  endtask

  // Output monitor: compares every valid output with the bench model (R1-R7)
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        checks++;
        if (pend.size() == 0) begin
          errors++;
          $display("FAIL R6 unexpected out_valid: actual=1 expected=0");
        end else begin
          exp_t e;
          e = pend.pop_front();
          if (int'($signed(out_beam_i)) != e.bi || int'($signed(out_beam_q)) != e.bq ||
              int'($signed(out_err_i)) != e.ei || int'($signed(out_err_q)) != e.eq ||
              cyc != e.due) begin
            errors++;
            $display("FAIL %s: actual beam=(%0d,%0d) err=(%0d,%0d) cyc=%0d expected beam=(%0d,%0d) err=(%0d,%0d) cyc=%0d",
                     e.tag, $signed(out_beam_i), $signed(out_beam_q),
                     $signed(out_err_i), $signed(out_err_q), cyc,
                     e.bi, e.bq, e.ei, e.eq, e.due);
          end
        end
      end else if (pend.size() > 0 && pend[0].due <= cyc) begin
        checks++;
        errors++;
        $display("FAIL R6 missing out_valid for %s: actual=0 expected=1", pend[0].tag);
        void'(pend.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    clear_samples();
    for (int k = 0; k < NCH; k++) begin
      wmi[k] = 0;
      wmq[k] = 0;
    end

    // R8: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_beam_i !== '0 || out_err_i !== '0 || out_err_q !== '0) begin
      errors++;
      $display("FAIL R8 reset outputs: actual valid=%b beam_i=%0d err=(%0d,%0d) expected 0,0,(0,0)",
               out_valid, out_beam_i, out_err_i, out_err_q);
    end
    rst = 1'b0;
    mon_on = 1'b1;

    // R8: weights cleared, beam zero, error equals reference
    for (int k = 0; k < NCH; k++) begin
      si[k] = rs16(0);
      sq[k] = rs16(0);
    end
    ri = 1234; rq = -77;
    step(1'b1, "R8 zero weights after reset", 1'b0, 0, 0, 0);

    // R1: conjugate weighting on one element
    clear_samples();
    step(1'b0, "", 1'b1, 5, 0, 16384);
    si[5] = 16384; sq[5] = 0; ri = 0; rq = 0;
    step(1'b1, "R1 conjugate pure imaginary weight", 1'b0, 0, 0, 0);
    step(1'b0, "", 1'b1, 5, 12000, -5000);
    si[5] = 9000; sq[5] = -7000;
    step(1'b1, "R1 conjugate general weight", 1'b0, 0, 0, 0);

    // R9: only the addressed element changes
    step(1'b0, "", 1'b1, 5, 0, 0);
    step(1'b0, "", 1'b1, 7, 20000, 3000);
    for (int k = 0; k < NCH; k++) begin
      si[k] = rs16(1);
      sq[k] = rs16(1);
    end
    step(1'b1, "R9 single addressed write", 1'b0, 0, 0, 0);

    // R7: write on the same edge as a snapshot, then the next snapshot
    step(1'b1, "R7 same-edge write uses old weight", 1'b1, 7, -15000, 9000);
    step(1'b1, "R7 following snapshot uses new weight", 1'b0, 0, 0, 0);

    // R3: rounding ties go up
    clear_weights();
    step(1'b0, "", 1'b1, 0, 16384, 0);
    clear_samples();
    si[0] = 1;  step(1'b1, "R3 tie +0.5 rounds to 1", 1'b0, 0, 0, 0);
    si[0] = -1; step(1'b1, "R3 tie -0.5 rounds to 0", 1'b0, 0, 0, 0);
    si[0] = 3;  step(1'b1, "R3 tie 1.5 rounds to 2", 1'b0, 0, 0, 0);

    // R4 / R5: saturation of beam and of error
    for (int k = 0; k < NCH; k++) step(1'b0, "", 1'b1, k, 32767, 0);
    for (int k = 0; k < NCH; k++) si[k] = 32767;
    ri = 0; rq = 0;
    step(1'b1, "R4 positive saturation", 1'b0, 0, 0, 0);
    for (int k = 0; k < NCH; k++) si[k] = -32768;
    step(1'b1, "R4 negative saturation and R5 error saturation high", 1'b0, 0, 0, 0);
    for (int k = 0; k < NCH; k++) si[k] = 32767;
    ri = -32768; rq = 32767;
    step(1'b1, "R5 error saturation low", 1'b0, 0, 0, 0);

    // R2 / R6: random weights, samples, gaps and writes
    for (int k = 0; k < NCH; k++) step(1'b0, "", 1'b1, k, rs16(2), rs16(2));
    for (int n = 0; n < 600; n++) begin
      bit ds, dw;
      ds = ($urandom_range(0, 99) < 75);
      dw = ($urandom_range(0, 99) < 20);
      for (int k = 0; k < NCH; k++) begin
        si[k] = rs16(3);
        sq[k] = rs16(3);
      end
      ri = rs16(0);
      rq = rs16(0);
      step(ds, "R2 R6 random stream", dw, int'($urandom_range(0, NCH - 1)), rs16(2), rs16(2));
    end

    // R2: silent array gives zero beam
    clear_samples();
    ri = 555; rq = -555;
    step(1'b1, "R2 silent array", 1'b0, 0, 0, 0);

    repeat (8) @(negedge clk);
    checks++;
    if (pend.size() != 0) begin
      errors++;
      $display("FAIL R6 outstanding results: actual=%0d expected=0", pend.size());
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule